// File: doc/BRIEF.md
# Key-Locked Alternate-Function Guard

This block protects the alternate-function-select setting of an eight-pin port against accidental change. A 32-bit key register holds a lock state. Software unlocks the block by writing one specific key value. While the block is unlocked, software may load an 8-bit commit mask. Only the select bits whose commit bit is set can be changed by later writes to the alternate-function-select register. The other select bits keep their value no matter what is written.

The block sits on the port's simple register bus. A write is a request with the write enable set, and it takes effect at the next rising clock edge. A read is a request with the write enable clear, and it returns data combinationally in the same cycle. The select value is also exported continuously on a dedicated output, so the pin multiplexing logic can use it. That multiplexing logic is outside this block.

Top module: `afsel_lock_guard`

## Requirements
- R1: After reset the block is locked (the lock register reads 1), the commit register reads 0xFF, and the select register and `afsel_o` are 0.
- R2: A write of exactly 0x0ACCE551 to the lock register (offset 0x520) unlocks the block. From the next cycle, reading the lock register returns 0.
- R3: A write of any other 32-bit value to the lock register locks the block, and the lock register then reads 1. This includes a value that differs from the key only in bits 31..24.
- R4: A write to the commit register (offset 0x524) while the block is locked leaves the commit register unchanged.
- R5: While the block is unlocked, a commit write stores bits 7..0 of the write data. Bits 31..8 are ignored, and the register reads back zero-extended.
- R6: A write to the select register (offset 0x420) updates only the bits whose commit bit is 1. Each such bit takes bit i of the write data, and every other bit keeps its old value.
- R7: `afsel_o` always equals the select register. Reading offset 0x420 returns the same value zero-extended.
- R8: The lock state changes only on a write to the lock register. Reads, idle cycles and writes to other offsets leave it as it was.
- R9: A read at any other offset returns 0. A write to any other offset changes no register.
- R10: A read request (`we_i` low) changes no register, whatever is on `wdata_i`. When `req_i` is low, or `we_i` is high, `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read request |
| afsel_o | output | 8 | Current alternate-function-select value |

## Verification
The bench builds the block with its default parameters: eight pins, 12-bit offsets, a 32-bit data path and the default key. With those values, every offset used in the requirements can be reached by the stimulus. A near-miss key that differs only in the top byte can also be applied, and it shows that the comparison covers the full word. With eight commit bits, the bench can apply mixed masks such as 0x0F and 0x00. These masks show the partial and the fully frozen update of the select register. They also show that the mask is frozen again once the block is locked.

// File: rtl/afsel_guard_pkg.sv
package afsel_guard_pkg;
  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_AFSEL  = 2'd1,
    SEL_LOCK   = 2'd2,
    SEL_COMMIT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/guard_addr_dec.sv
module guard_addr_dec
  import afsel_guard_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned AFSEL_OFS  = 12'h420,
  parameter int unsigned LOCK_OFS   = 12'h520,
  parameter int unsigned COMMIT_OFS = 12'h524
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam logic [ADDR_W-1:0] AfselA  = ADDR_W'(AFSEL_OFS);
  localparam logic [ADDR_W-1:0] LockA   = ADDR_W'(LOCK_OFS);
  localparam logic [ADDR_W-1:0] CommitA = ADDR_W'(COMMIT_OFS);

  always_comb begin
    if (addr_i == AfselA)       sel_o = SEL_AFSEL;
    else if (addr_i == LockA)   sel_o = SEL_LOCK;
    else if (addr_i == CommitA) sel_o = SEL_COMMIT;
    else                        sel_o = SEL_NONE;
  end
endmodule

// File: rtl/guard_lock.sv
module guard_lock #(
  parameter int unsigned    DATA_W = 32,
  parameter logic [31:0]    KEY    = 32'h0ACC_E551
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  localparam logic [DATA_W-1:0] KeyW = DATA_W'(KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   locked_o <= 1'b1;
    else if (wr_i) locked_o <= (wdata_i != KeyW);
  end
endmodule

// File: rtl/guard_masked_reg.sv
module guard_masked_reg #(
  parameter int unsigned   W     = 8,
  parameter logic [W-1:0]  RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  // one flop per bit; each bit loads only when its mask bit is set
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q_o[b] <= RST_V[b];
      else if (wr_i && mask_i[b]) q_o[b] <= wdata_i[b];
    end
  end
endmodule

// File: rtl/afsel_lock_guard.sv
module afsel_lock_guard
  import afsel_guard_pkg::*;
#(
  parameter int unsigned N_PINS     = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned AFSEL_OFS  = 12'h420,
  parameter int unsigned LOCK_OFS   = 12'h520,
  parameter int unsigned COMMIT_OFS = 12'h524,
  parameter logic [31:0] KEY        = 32'h0ACC_E551
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_PINS-1:0] afsel_o
);
  localparam int unsigned PadW = DATA_W - N_PINS;

  reg_sel_e          sel;
  logic              wr, rd;
  logic              locked_q;
  logic [N_PINS-1:0] commit_q;
  logic [N_PINS-1:0] afsel_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  guard_addr_dec #(
    .ADDR_W(ADDR_W), .AFSEL_OFS(AFSEL_OFS),
    .LOCK_OFS(LOCK_OFS), .COMMIT_OFS(COMMIT_OFS)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  guard_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr && sel == SEL_LOCK),
    .wdata_i (wdata_i),
    .locked_o(locked_q)
  );

  // commit mask: writable only while unlocked
  guard_masked_reg #(.W(N_PINS), .RST_V({N_PINS{1'b1}})) u_commit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr && sel == SEL_COMMIT && !locked_q),
    .mask_i ({N_PINS{1'b1}}),
    .wdata_i(wdata_i[N_PINS-1:0]),
    .q_o    (commit_q)
  );

  // select register: per-bit update gated by commit mask
  guard_masked_reg #(.W(N_PINS), .RST_V('0)) u_afsel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr && sel == SEL_AFSEL),
    .mask_i (commit_q),
    .wdata_i(wdata_i[N_PINS-1:0]),
    .q_o    (afsel_q)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        SEL_AFSEL:  rdata_o = {{PadW{1'b0}}, afsel_q};
        SEL_LOCK:   rdata_o = {{(DATA_W-1){1'b0}}, locked_q};
        SEL_COMMIT: rdata_o = {{PadW{1'b0}}, commit_q};
        default:    rdata_o = '0;
      endcase
    end
  end

  assign afsel_o = afsel_q;
endmodule

// File: rtl/afsel_guard_chk.sv
module afsel_guard_chk #(
  parameter int unsigned N_PINS     = 8,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned AFSEL_OFS  = 12'h420,
  parameter int unsigned LOCK_OFS   = 12'h520,
  parameter int unsigned COMMIT_OFS = 12'h524,
  parameter logic [31:0] KEY        = 32'h0ACC_E551
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N_PINS-1:0] afsel_o,
  input logic              locked,
  input logic [N_PINS-1:0] commit
);
  logic wr_lock, wr_commit, wr_afsel;
  assign wr_lock   = req_i && we_i && addr_i == ADDR_W'(LOCK_OFS);
  assign wr_commit = req_i && we_i && addr_i == ADDR_W'(COMMIT_OFS);
  assign wr_afsel  = req_i && we_i && addr_i == ADDR_W'(AFSEL_OFS);

  p_key_unlocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lock && wdata_i == DATA_W'(KEY) |=> !locked);

  p_other_locks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lock && wdata_i != DATA_W'(KEY) |=> locked);

  p_commit_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked && wr_commit |=> $stable(commit));

  p_commit_only_on_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_commit |=> $stable(commit));

  p_afsel_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_afsel |=> ((afsel_o ^ $past(afsel_o)) & ~$past(commit)) == '0);

  p_afsel_only_on_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_afsel |=> $stable(afsel_o));

  p_lock_persists_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lock |=> $stable(locked));
endmodule

bind afsel_lock_guard afsel_guard_chk #(
  .N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AFSEL_OFS(AFSEL_OFS),
  .LOCK_OFS(LOCK_OFS), .COMMIT_OFS(COMMIT_OFS), .KEY(KEY)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .afsel_o(afsel_o),
  .locked (locked_q),
  .commit (commit_q)
);

// File: tb/sim_afsel_lock_guard.sv
`timescale 1ns/1ps
module sim_afsel_lock_guard;
  localparam logic [11:0] A_AFSEL  = 12'h420;
  localparam logic [11:0] A_LOCK   = 12'h520;
  localparam logic [11:0] A_COMMIT = 12'h524;
  localparam logic [31:0] KEY      = 32'h0ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  afsel;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  bit         m_locked;
  logic [7:0] m_commit, m_afsel;

  always #10 clk = ~clk;

  afsel_lock_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .afsel_o(afsel)
  );

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      A_AFSEL:  return {24'h0, m_afsel};
      A_LOCK:   return {31'h0, m_locked};
      A_COMMIT: return {24'h0, m_commit};
      default:  return 32'h0;
    endcase
  endfunction

  task automatic check(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    case (a)
      A_LOCK:   m_locked = (d != KEY);
      A_COMMIT: if (!m_locked) m_commit = d[7:0];
      A_AFSEL:  m_afsel = (m_afsel & ~m_commit) | (d[7:0] & m_commit);
      default: ;
    endcase
  endtask

  task automatic rd(logic [11:0] a, string req_tag, logic [31:0] d = 32'h0);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; wdata = d;
    #5;
    check(req_tag, rdata, model_read(a));
  endtask

  // R7: exported value compared every clock
  always @(negedge clk) if (rst_n) check("R7", {24'h0, afsel}, {24'h0, m_afsel});

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    m_locked = 1; m_commit = 8'hFF; m_afsel = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(A_LOCK, "R1"); rd(A_COMMIT, "R1"); rd(A_AFSEL, "R1");
    // R10 idle output is zero
    @(negedge clk); req = 1'b0; #5 check("R10", rdata, 32'h0);

    wr(A_AFSEL, 32'hFFFF_FFA5);  rd(A_AFSEL, "R6");           // full mask
    wr(A_COMMIT, 32'h0F);        rd(A_COMMIT, "R4");          // locked
    wr(A_LOCK, 32'h8ACC_E551);   rd(A_LOCK, "R3");            // near miss
    rd(A_LOCK, "R10", KEY);      rd(A_LOCK, "R10");           // read with key on bus
    wr(A_LOCK, KEY);             rd(A_LOCK, "R2");
    // R8 persistence over other traffic
    rd(A_AFSEL, "R8"); wr(12'h424, 32'hFF); wr(A_AFSEL, 32'hA5);
    @(negedge clk); req = 1'b0; repeat (4) @(negedge clk);
    rd(A_LOCK, "R8");
    wr(A_COMMIT, 32'hFFFF_FF0F); rd(A_COMMIT, "R5");
    wr(A_AFSEL, 32'h5A);         rd(A_AFSEL, "R6");           // expect AA
    wr(A_LOCK, 32'h0);           rd(A_LOCK, "R3");
    wr(A_COMMIT, 32'h00);        rd(A_COMMIT, "R4");
    wr(A_AFSEL, 32'h00);         rd(A_AFSEL, "R6");           // expect A0
    // R9 unmapped
    wr(12'h41C, 32'hFF); wr(12'h000, 32'hFF);
    rd(12'h424, "R9"); rd(12'h000, "R9"); rd(A_AFSEL, "R9"); rd(A_COMMIT, "R9");
    // frozen mask: unlock, clear commit, relock, select writes ignored
    wr(A_LOCK, KEY); wr(A_COMMIT, 32'h00); wr(A_LOCK, 32'h1);
    wr(A_AFSEL, 32'hFF);         rd(A_AFSEL, "R6");
    wr(A_LOCK, KEY); wr(A_COMMIT, 32'h3C);
    rd(A_COMMIT, "R5");          rd(A_LOCK, "R2");
    wr(A_AFSEL, 32'h0F);         rd(A_AFSEL, "R6");           // expect 8C
    @(negedge clk); req = 1'b0; we = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule